// File: doc/BRIEF.md
# I2S Microphone Slot Transmitter

This block is the output stage of a digital microphone that sits as a slave on an I2S bus. An external master drives the bit clock (SCK) and the word-select line (WS). The block follows both lines and places one 24-bit two's-complement sample in its own half of each stereo frame. A static channel-select pin decides which half is its own. The output is a data bit plus an output-enable, so two such transmitters, one set to each channel, can share a single data wire that has a pull-down.

SCK and WS are asynchronous to the local system clock `clk`. The block synchronizes both lines and reacts to each SCK falling edge. It turns data around on that falling edge, so the master can capture it on the following rising edge. Samples arrive on a parallel port with a one-cycle valid strobe. The most recent sample is copied into the shift register at the start of the block's own half-frame. If no new sample has arrived, the previous one is sent again.

Top module: `i2s_mic_tx`

## Requirements
- R1: After reset, `sd_oe` and `sd_out` are 0. They stay 0 until a change of WS level has been seen at an SCK falling edge after reset. The first falling edge after reset only records the WS level.
- R2: Slot positions count from 0 at the SCK falling edge where WS changes level. The word goes out MSB first: slot 1 carries bit 23 and slot 24 carries bit 0, with `sd_oe` high over slots 1 through 24.
- R3: With `chan_sel` = 0 the block drives only in the half-frame where WS is low (left). With `chan_sel` = 1 it drives only where WS is high (right). The other half-frame stays entirely undriven.
- R4: `sd_oe` falls at the SCK falling edge right after the LSB (slot 25) and stays low through slot 31. Whenever `sd_oe` is 0, `sd_out` is 0.
- R5: `sd_out` and `sd_oe` change only in response to an SCK falling edge. They hold steady through the following SCK high phase.
- R6: The word is taken at slot 0 of the block's own half-frame from the most recent sample accepted on `smp_valid`. Without a new sample, the previous word is repeated. After reset the held sample is zero.
- R7: A sample accepted while a word is being shifted out leaves the bits in flight unchanged. It appears in the next own half-frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local system clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_sel | input | 1 | Static channel choice: 0 = WS-low half, 1 = WS-high half |
| sck | input | 1 | Bit clock from the bus master (asynchronous) |
| ws | input | 1 | Word select from the bus master (asynchronous) |
| smp_data | input | DATA_W | Parallel two's-complement sample |
| smp_valid | input | 1 | One-cycle strobe accepting `smp_data` |
| sd_out | output | 1 | Serial data bit toward the shared line |
| sd_oe | output | 1 | Output enable for the shared line |

## Verification
The bound checker watches four things on every clock:
- the output pair changes only in the cycle after a detected SCK fall;
- the enable is never high outside the selected WS level or before alignment;
- the data bit is zero whenever the enable is low;
- the enable rises at slot 1 and falls at slot 25.

Which bit value lands in which slot, and which sample a given half-frame carries, can only be shown by the bench's frame scenarios. These include the repeat-without-new-sample case and the mid-word sample arrival.

// File: rtl/i2s_mic_pkg.sv
package i2s_mic_pkg;

  typedef enum logic {
    CH_WS_LOW  = 1'b0,
    CH_WS_HIGH = 1'b1
  } chan_e;

  // Next slot position after one SCK fall within a half-frame, held at the last slot.
  function automatic int unsigned slot_advance(int unsigned pos, int unsigned slot_w);
    if (pos + 1 >= slot_w) return slot_w - 1;
    return pos + 1;
  endfunction

  // True for the slot positions that carry a data bit (1 .. data_w).
  function automatic logic slot_carries_bit(int unsigned pos, int unsigned data_w);
    return (pos >= 1) && (pos <= data_w);
  endfunction

  // Data bit index sent in a given slot position (MSB in slot 1).
  function automatic int unsigned slot_bit_index(int unsigned pos, int unsigned data_w);
    return data_w - pos;
  endfunction

endpackage

// File: rtl/i2s_mic_sync.sv
module i2s_mic_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign lvl[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2s_mic_slot_tracker.sv
module i2s_mic_slot_tracker
  import i2s_mic_pkg::*;
#(
  parameter int unsigned SLOT_W = 32,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ws_lvl,
  output logic [CNT_W-1:0] pos,
  output logic [CNT_W-1:0] pos_nxt,
  output logic             aligned,
  output logic             aligned_nxt
);

  logic ws_last;
  logic primed;
  logic ws_edge;

  assign ws_edge     = step & primed & (ws_lvl != ws_last);
  assign aligned_nxt = aligned | ws_edge;

  always_comb begin
    if (ws_edge) pos_nxt = '0;
    else         pos_nxt = CNT_W'(slot_advance(int'(pos), SLOT_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_last <= 1'b0;
      primed  <= 1'b0;
      aligned <= 1'b0;
      pos     <= '0;
    end else if (step) begin
      primed  <= 1'b1;
      ws_last <= ws_lvl;
      aligned <= aligned_nxt;
      if (aligned_nxt) pos <= pos_nxt;
    end
  end

endmodule

// File: rtl/i2s_mic_sample_hold.sv
module i2s_mic_sample_hold #(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic [DATA_W-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word <= '0;
    else if (smp_valid) word <= smp_data;
  end

endmodule

// File: rtl/i2s_mic_shifter.sv
module i2s_mic_shifter
  import i2s_mic_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              aligned_nxt,
  input  logic              own_half,
  input  logic [CNT_W-1:0]  pos_nxt,
  input  logic [DATA_W-1:0] word,
  output logic              sd_out,
  output logic              sd_oe
);

  logic [DATA_W-1:0] shreg;
  logic              load_evt;
  logic              drive_evt;
  logic              active;

  assign active    = step & aligned_nxt & own_half;
  assign load_evt  = active & (pos_nxt == '0);
  assign drive_evt = active & slot_carries_bit(int'(pos_nxt), DATA_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      sd_out <= 1'b0;
      sd_oe  <= 1'b0;
    end else begin
      if (load_evt)       shreg <= word;
      else if (drive_evt) shreg <= {shreg[DATA_W-2:0], 1'b0};
      if (step) begin
        sd_oe  <= drive_evt;
        sd_out <= drive_evt & shreg[DATA_W-1];
      end
    end
  end

endmodule

// File: rtl/i2s_mic_tx.sv
module i2s_mic_tx
  import i2s_mic_pkg::*;
#(
  parameter int unsigned DATA_W      = 24,
  parameter int unsigned SLOT_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_sel,
  input  logic              sck,
  input  logic              ws,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              smp_valid,
  output logic              sd_out,
  output logic              sd_oe
);

  localparam int unsigned CNT_W = $clog2(SLOT_W);

  logic [1:0]        bus_lvl;
  logic              sck_lvl;
  logic              ws_lvl;
  logic              sck_prev;
  logic              sck_fall;
  logic [CNT_W-1:0]  slot_pos;
  logic [CNT_W-1:0]  slot_pos_nxt;
  logic              aligned;
  logic              aligned_nxt;
  logic              own_half;
  logic [DATA_W-1:0] held_word;

  i2s_mic_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({ws, sck}),
    .lvl   (bus_lvl)
  );

  assign sck_lvl = bus_lvl[0];
  assign ws_lvl  = bus_lvl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_lvl;
  end

  assign sck_fall = sck_prev & ~sck_lvl;
  assign own_half = (chan_e'(ws_lvl) == chan_e'(chan_sel));

  i2s_mic_slot_tracker #(.SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (sck_fall),
    .ws_lvl      (ws_lvl),
    .pos         (slot_pos),
    .pos_nxt     (slot_pos_nxt),
    .aligned     (aligned),
    .aligned_nxt (aligned_nxt)
  );

  i2s_mic_sample_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .word      (held_word)
  );

  i2s_mic_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (sck_fall),
    .aligned_nxt (aligned_nxt),
    .own_half    (own_half),
    .pos_nxt     (slot_pos_nxt),
    .word        (held_word),
    .sd_out      (sd_out),
    .sd_oe       (sd_oe)
  );

endmodule

// File: rtl/i2s_mic_tx_chk.sv
module i2s_mic_tx_chk #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             chan_sel,
  input logic             ws_lvl,
  input logic             sck_fall,
  input logic             aligned,
  input logic [CNT_W-1:0] slot_pos,
  input logic             sd_out,
  input logic             sd_oe
);

  // R1
  no_drive_before_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned |-> !sd_oe);

  // R3
  own_half_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> (ws_lvl == chan_sel));

  // R4
  quiet_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);

  // R4
  release_after_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe) |-> (int'(slot_pos) == DATA_W + 1));

  // R2
  msb_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_oe) |-> (int'(slot_pos) == 1));

  // R2
  window_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_oe |-> ((int'(slot_pos) >= 1) && (int'(slot_pos) <= DATA_W)));

  // R5
  change_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sck_fall) |-> ($stable(sd_oe) && $stable(sd_out)));

endmodule

bind i2s_mic_tx i2s_mic_tx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_sel (chan_sel),
  .ws_lvl   (ws_lvl),
  .sck_fall (sck_fall),
  .aligned  (aligned),
  .slot_pos (slot_pos),
  .sd_out   (sd_out),
  .sd_oe    (sd_oe)
);

// File: tb/i2s_mic_tx_test.sv
module i2s_mic_tx_test;

  localparam int DW = 24;
  localparam int SW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_sel = 1'b0;
  logic          sck = 1'b1;
  logic          ws = 1'b1;
  logic [DW-1:0] smp_data = '0;
  logic          smp_valid = 1'b0;
  logic          sd_out;
  logic          sd_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  i2s_mic_tx uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .chan_sel  (chan_sel),
    .sck       (sck),
    .ws        (ws),
    .smp_data  (smp_data),
    .smp_valid (smp_valid),
    .sd_out    (sd_out),
    .sd_oe     (sd_oe)
  );

  // {chan_sel, sample}
  localparam logic [DW:0] VEC [6] = '{
    {1'b0, 24'h800000},
    {1'b1, 24'h7FFFFF},
    {1'b0, 24'hA5A5A5},
    {1'b1, 24'h000001},
    {1'b0, 24'hFFFFFF},
    {1'b1, 24'h123456}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected {oe, data} for one slot, worked out from R2/R3/R4.
  function automatic logic [1:0] expect_slot(input int k, input bit drive, input logic [DW-1:0] w);
    if (drive && k >= 1 && k <= DW) return {1'b1, w[DW - k]};
    return 2'b00;
  endfunction

  task automatic offer(input logic [DW-1:0] w);
    @(negedge clk);
    smp_data  = w;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  // One SCK period: fall (with optional WS change and sample offer), check, rise, recheck.
  task automatic sck_slot(input int k, input logic ws_val, input bit drive, input logic [DW-1:0] w,
                          input bit inj, input logic [DW-1:0] inj_w, input string tag);
    logic [1:0] e;
    @(negedge clk);
    sck = 1'b0;
    ws  = ws_val;
    if (inj) begin
      smp_data  = inj_w;
      smp_valid = 1'b1;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    e = expect_slot(k, drive, w);
    chk(tag, $sformatf("slot %0d low phase {oe,sd}", k), {30'd0, sd_oe, sd_out}, {30'd0, e});
    sck = 1'b1;
    repeat (6) @(negedge clk);
    chk("R5", $sformatf("slot %0d high phase {oe,sd}", k), {30'd0, sd_oe, sd_out}, {30'd0, e});
  endtask

  task automatic run_half(input logic ws_val, input bit drive, input logic [DW-1:0] w,
                          input int inj_slot, input logic [DW-1:0] inj_w, input string tag);
    for (int k = 0; k < SW; k++)
      sck_slot(k, ws_val, drive, w, k == inj_slot, inj_w, tag);
  endtask

  // Left half (WS low) then right half (WS high).
  task automatic run_frame(input logic sel, input logic [DW-1:0] w,
                           input int inj_slot, input logic [DW-1:0] inj_w, input string tag);
    run_half(1'b0, sel == 1'b0, w, (sel == 1'b0) ? inj_slot : -1, inj_w, tag);
    run_half(1'b1, sel == 1'b1, w, (sel == 1'b1) ? inj_slot : -1, inj_w, tag);
  endtask

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst_n    = 1'b0;
    chan_sel = sel;
    sck      = 1'b1;
    ws       = 1'b1;
    smp_valid = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "after reset {oe,sd}", {30'd0, sd_oe, sd_out}, 32'd0);
    // WS stays high: no level change seen yet, so the line stays released
    for (int k = 0; k < 3; k++)
      sck_slot(k, 1'b1, 1'b0, '0, 1'b0, '0, "R1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Vector table: each row gets a fresh reset, a sample and two frames.
    for (int i = 0; i < 6; i++) begin
      do_reset(VEC[i][DW]);
      offer(VEC[i][DW-1:0]);
      run_frame(VEC[i][DW], VEC[i][DW-1:0], -1, '0, "R2/R3/R4");
      // no new sample: the same word is repeated
      run_frame(VEC[i][DW], VEC[i][DW-1:0], -1, '0, "R6");
    end

    // R6: a reset clears the held sample, so zeros go out with the enable high
    do_reset(1'b0);
    run_frame(1'b0, 24'h000000, -1, '0, "R6");

    // R7: a sample arriving mid-word leaves the word in flight intact
    do_reset(1'b0);
    offer(24'hC3A50F);
    run_frame(1'b0, 24'hC3A50F, 10, 24'h5A0FF1, "R7");
    run_frame(1'b0, 24'h5A0FF1, -1, '0, "R7");

    // R6: right channel, sample offered in the left half is sent in the following right half
    do_reset(1'b1);
    offer(24'h111111);
    run_half(1'b0, 1'b0, 24'h111111, 5, 24'h0BEEF1, "R6");
    run_half(1'b1, 1'b1, 24'h0BEEF1, -1, '0, "R6");
    run_frame(1'b1, 24'h0BEEF1, -1, '0, "R3");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule